// File: doc/BRIEF.md
# LCD Frame Marker and Polarity-Reversal Generator

This block drives two timing outputs of a scanned liquid-crystal panel controller: the frame marker, which tells the panel that a new frame begins, and the polarity-reversal signal, which keeps the liquid crystal from being driven with a net DC level. It runs on the system clock. The line-latch pulse and two level indications arrive on that same clock. One indication is high for the whole of the first line of a frame and the other for the whole of the last line. Each indication is set at least one clock before that line's latch pulse rises and is held until after the pulse has fallen. A frame has at least two lines.

The frame marker has two alignments. In the line-aligned alignment it rises as soon as the first line is indicated, before that line's latch pulse, and it falls after the pulse ends. In the boundary-spanning alignment it rises when the last line's latch pulse falls and drops when the first line's latch pulse falls. The polarity output either flips once per frame or runs as a square wave counted in latch pulses. Which of the two it does, and the half-period of the square wave, come from an 8-bit control word. That word is copied into the block only at the frame boundary, so a write in the middle of a frame never disturbs the frame in progress.

Top module: `lcd_flm_ac_gen`

## Requirements
- R1: While reset is active, both the frame marker and the polarity output are low.
- R2: In line-aligned mode (mode input low), the frame marker is high one clock after the first-line indication is sampled high, while that line's latch pulse has not yet ended.
- R3: In line-aligned mode, the frame marker goes low one clock after the falling edge of the first line's latch pulse. It stays low for every other line.
- R4: In boundary-spanning mode (mode input high), the frame marker goes high one clock after the falling edge of the last line's latch pulse. It holds that level until R5 clears it.
- R5: In boundary-spanning mode, the frame marker goes low one clock after the falling edge of the first line's latch pulse.
- R6: With control bit 7 clear (per-frame mode), the polarity output inverts one clock after the falling edge of the last line's latch pulse and at no other time.
- R7: With control bit 7 set (square-wave mode), the polarity output inverts on every (N+1)-th latch-pulse falling edge, where N is control bits 4 to 0.
- R8: The latch-pulse count restarts from zero after the falling edge of the last line's latch pulse. That falling edge is first counted under the settings already in force.
- R9: The control word is sampled only at the falling edge of the last line's latch pulse. A change during a frame has no effect until the frame ends.
- R10: The polarity output changes only one clock after a latch-pulse falling edge. Control bits 6 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; internal release is synchronised |
| lp | input | 1 | Line-latch pulse, active high |
| first_line | input | 1 | High throughout the first line of a frame |
| last_line | input | 1 | High throughout the last line of a frame |
| alt_flm | input | 1 | Frame-marker alignment: 0 line-aligned, 1 boundary-spanning |
| ac_ctrl | input | 8 | Bit 7 square-wave enable, bits 4..0 half-period minus one, bits 6..5 unused |
| flm | output | 1 | Frame marker |
| ac | output | 1 | Polarity-reversal output |

## Verification
Every result is due exactly one rising clock edge after its cause. The frame marker follows one edge after a first-line indication is set, and both outputs follow one edge after the clock that first samples the latch pulse low. The bench changes its inputs on the falling clock edge and reads the outputs on the next falling edge, so exactly one register stage lies between stimulus and sample. While the latch pulse is high, and in the clocks before its fall, the bench also checks that the polarity output still holds the reference value, which proves that nothing but a falling edge moves it.

// File: rtl/lcdfa_pkg.sv
package lcdfa_pkg;

  // Alignment of the frame marker with respect to the latch pulse.
  typedef enum logic {
    FLM_LINE = 1'b0,  // marker covers the first line up to its pulse end
    FLM_SPAN = 1'b1   // marker spans from last-line pulse end to first-line pulse end
  } flm_mode_e;

  // Behaviour of the polarity output.
  typedef enum logic {
    AC_PER_FRAME = 1'b0,
    AC_COUNTED   = 1'b1
  } ac_mode_e;

endpackage

// File: rtl/lcdfa_rst_sync.sv
module lcdfa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/lcdfa_lp_edge.sv
module lcdfa_lp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lp,
  output logic lp_fall
);

  logic lp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= lp;
  end

  // High in the first clock that samples the pulse low after it was high.
  assign lp_fall = lp_q & ~lp;

endmodule

// File: rtl/lcdfa_flm_gen.sv
module lcdfa_flm_gen
  import lcdfa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic alt_mode,
  input  logic lp_fall,
  input  logic first_line,
  input  logic last_line,
  output logic flm
);

  flm_mode_e mode;
  logic      flm_q, flm_d;
  logic      used_q, used_d;   // first-line pulse already ended

  assign mode = alt_mode ? FLM_SPAN : FLM_LINE;

  always_comb begin
    used_d = used_q;
    if (!first_line)  used_d = 1'b0;
    else if (lp_fall) used_d = 1'b1;
  end

  always_comb begin
    flm_d = flm_q;
    case (mode)
      FLM_SPAN: begin
        if (lp_fall && last_line)       flm_d = 1'b1;
        else if (lp_fall && first_line) flm_d = 1'b0;
      end
      default: begin
        flm_d = first_line && !used_q && !lp_fall;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flm_q  <= 1'b0;
      used_q <= 1'b0;
    end else begin
      flm_q  <= flm_d;
      used_q <= used_d;
    end
  end

  assign flm = flm_q;

endmodule

// File: rtl/lcdfa_ac_gen.sv
module lcdfa_ac_gen
  import lcdfa_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_fall,
  input  logic             last_line,
  input  logic             ctrl_en,
  input  logic [CNT_W-1:0] ctrl_cnt,
  output logic             ac,
  output logic             en_cur
);

  ac_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ac_q, ac_d;

  always_comb begin
    mode_d = mode_q;
    lim_d  = lim_q;
    cnt_d  = cnt_q;
    ac_d   = ac_q;
    // Count this falling edge with the settings in force.
    if (mode_q == AC_COUNTED) begin
      if (cnt_q == lim_q) begin
        ac_d  = ~ac_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (last_line) begin
      ac_d = ~ac_q;
    end
    // Frame boundary: take the new control word, restart the count.
    if (last_line) begin
      cnt_d  = '0;
      mode_d = ctrl_en ? AC_COUNTED : AC_PER_FRAME;
      lim_d  = ctrl_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AC_PER_FRAME;
      lim_q  <= '0;
      cnt_q  <= '0;
      ac_q   <= 1'b0;
    end else if (lp_fall) begin
      mode_q <= mode_d;
      lim_q  <= lim_d;
      cnt_q  <= cnt_d;
      ac_q   <= ac_d;
    end
  end

  assign ac     = ac_q;
  assign en_cur = (mode_q == AC_COUNTED);

endmodule

// File: rtl/lcd_flm_ac_gen.sv
module lcd_flm_ac_gen #(
  parameter int CTRL_W      = 8,
  parameter int CNT_W       = 5,
  parameter int EN_BIT      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp,
  input  logic              first_line,
  input  logic              last_line,
  input  logic              alt_flm,
  input  logic [CTRL_W-1:0] ac_ctrl,
  output logic              flm,
  output logic              ac
);

  localparam int SPARE_LO = CNT_W;
  localparam int SPARE_HI = EN_BIT - 1;
  localparam int TOP_HI   = CTRL_W - 1;

  logic rst_sync_n;
  logic lp_fall;
  logic ac_en_cur;

  generate
    if (SPARE_HI >= SPARE_LO) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^ac_ctrl[SPARE_HI:SPARE_LO];
    end
    if (TOP_HI > EN_BIT) begin : g_top
      logic unused_top;
      assign unused_top = ^ac_ctrl[TOP_HI:EN_BIT+1];
    end
  endgenerate

  lcdfa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  lcdfa_lp_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lp      (lp),
    .lp_fall (lp_fall)
  );

  lcdfa_flm_gen u_flm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .alt_mode   (alt_flm),
    .lp_fall    (lp_fall),
    .first_line (first_line),
    .last_line  (last_line),
    .flm        (flm)
  );

  lcdfa_ac_gen #(.CNT_W(CNT_W)) u_ac (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lp_fall   (lp_fall),
    .last_line (last_line),
    .ctrl_en   (ac_ctrl[EN_BIT]),
    .ctrl_cnt  (ac_ctrl[CNT_W-1:0]),
    .ac        (ac),
    .en_cur    (ac_en_cur)
  );

endmodule

// File: rtl/lcd_flm_ac_chk.sv
module lcd_flm_ac_chk (
  input logic clk,
  input logic rst_n,
  input logic lp_fall,
  input logic first_line,
  input logic last_line,
  input logic alt_flm,
  input logic ac_en_cur,
  input logic flm,
  input logic ac
);

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> (flm === 1'b0 && ac === 1'b0));

  a_r3_line_flm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_flm && lp_fall && first_line) |=> !flm);

  a_r2_flm_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flm) |-> ($past(first_line) || $past(lp_fall && last_line)));

  a_r4_span_flm_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_flm && lp_fall && last_line) |=> flm);

  a_r5_span_flm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_flm && lp_fall && first_line && !last_line) |=> !flm);

  a_r6_frame_ac_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ac_en_cur && lp_fall && !last_line) |=> $stable(ac));

  a_r10_ac_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac) |-> $past(lp_fall));

endmodule

bind lcd_flm_ac_gen lcd_flm_ac_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .lp_fall    (lp_fall),
  .first_line (first_line),
  .last_line  (last_line),
  .alt_flm    (alt_flm),
  .ac_en_cur  (ac_en_cur),
  .flm        (flm),
  .ac         (ac)
);

// File: tb/lcd_flm_ac_gen_tb.sv
module lcd_flm_ac_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       lp;
  logic       first_line;
  logic       last_line;
  logic       alt_flm;
  logic [7:0] ac_ctrl;
  logic       flm;
  logic       ac;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference state
  bit m_ac, m_flm, m_en;
  int m_lim, m_cnt;

  lcd_flm_ac_gen u_dut (
    .clk(clk), .rst_n(rst_n), .lp(lp), .first_line(first_line),
    .last_line(last_line), .alt_flm(alt_flm), .ac_ctrl(ac_ctrl),
    .flm(flm), .ac(ac)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ac = 0; m_flm = 0; m_en = 0; m_lim = 0; m_cnt = 0;
  endtask

  // Reference reaction to one latch-pulse falling edge.
  task automatic model_fall(input bit first, input bit last);
    if (m_en) begin
      if (m_cnt == m_lim) begin m_ac = !m_ac; m_cnt = 0; end
      else m_cnt++;
    end else if (last) begin
      m_ac = !m_ac;
    end
    if (last) begin
      m_cnt = 0;
      m_en  = ac_ctrl[7];
      m_lim = int'(ac_ctrl[4:0]);
    end
    if (alt_flm) begin
      if (last)       m_flm = 1;
      else if (first) m_flm = 0;
    end else begin
      m_flm = 0;
    end
  endtask

  task automatic do_line(input bit first, input bit last, input string tag);
    string atag;
    int    gap;
    int    wid;
    @(negedge clk);
    first_line = first;
    last_line  = last;
    @(negedge clk);
    if (!alt_flm) m_flm = first;
    if (alt_flm)    check(flm == m_flm, "R4", flm, m_flm);
    else if (first) check(flm == m_flm, "R2", flm, m_flm);
    else            check(flm == m_flm, "R3", flm, m_flm);
    check(ac == m_ac, "R10", ac, m_ac);
    gap = int'($urandom_range(2, 0));
    repeat (gap) @(negedge clk);
    lp  = 1'b1;
    wid = int'($urandom_range(3, 1));
    repeat (wid) @(negedge clk);
    check(ac == m_ac, "R10", ac, m_ac);
    lp = 1'b0;
    @(negedge clk);
    if (tag != "")   atag = tag;
    else if (last)   atag = "R8";
    else if (m_en)   atag = "R7";
    else             atag = "R6";
    model_fall(first, last);
    check(ac == m_ac, atag, ac, m_ac);
    if (alt_flm && first) check(flm == m_flm, "R5", flm, m_flm);
    else if (alt_flm)     check(flm == m_flm, "R4", flm, m_flm);
    else                  check(flm == m_flm, "R3", flm, m_flm);
    gap = int'($urandom_range(2, 0));
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input string tag);
    for (int i = 0; i < n; i++) do_line(i == 0, i == n - 1, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(flm == 1'b0, "R1", flm, 0);
    check(ac == 1'b0, "R1", ac, 0);
    model_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit saved;
    void'($urandom(32'h5eed_1234));
    lp = 0; first_line = 0; last_line = 0; alt_flm = 0; ac_ctrl = 8'h00;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    do_reset();

    // Per-frame polarity, line-aligned marker
    for (int f = 0; f < 3; f++) run_frame(4, "");

    // R9: request square wave mid-frame; the frame keeps per-frame behaviour
    do_line(1'b1, 1'b0, "");
    ac_ctrl = 8'h80;
    saved = m_ac;
    do_line(1'b0, 1'b0, "R9");
    do_line(1'b0, 1'b0, "R9");
    check(ac == saved, "R9", ac, saved);
    do_line(1'b0, 1'b1, "R9");
    // count 0: every falling edge inverts
    run_frame(3, "R9");
    run_frame(3, "R7");

    // R10: bits 6..5 set do not change the square wave
    ac_ctrl = 8'hE2;
    run_frame(3, "");
    run_frame(5, "R10");
    ac_ctrl = 8'h82;
    run_frame(5, "R10");

    // Longest half-period needs a long frame
    ac_ctrl = 8'h9F;
    run_frame(3, "");
    run_frame(40, "R7");

    // Boundary-spanning marker
    alt_flm = 1'b1;
    ac_ctrl = 8'h01;
    for (int f = 0; f < 3; f++) run_frame(3, "");
    alt_flm = 1'b0;
    run_frame(3, "");

    // Random frames with mid-frame control changes
    for (int f = 0; f < 30; f++) begin
      int n;
      int chg;
      n   = int'($urandom_range(7, 2));
      chg = int'($urandom_range(7, 0));
      alt_flm = 1'($urandom_range(1, 0));
      for (int i = 0; i < n; i++) begin
        if (i == chg) ac_ctrl = 8'($urandom);
        do_line(i == 0, i == n - 1, "");
      end
    end

    // Reset in the middle of operation
    first_line = 0; last_line = 0; lp = 0; alt_flm = 0;
    do_reset();
    run_frame(3, "");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule